// File: doc/BRIEF.md
# Prioritized UART interrupt identifier

This block works out why a 16550-style UART wants the processor's attention. It holds the interrupt enable register and its own transmitter-empty pending flag. From these, the overrun flag, the receive-not-empty flag and the modem-delta flag, it selects the single most urgent enabled reason. It presents that reason as an 8-bit identification byte and drives a level interrupt line.

The register file around it supplies three strobes: one for each enable-register write, one for each transmit-data write, and one for each identifier read. The identification byte is combinational from the current state and flags, so the register file can return it in the same cycle as the read strobe. The interrupt line is registered. All pins are plain control and status pins: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_ident`

## Requirements
- R1: Reasons are ranked, highest first, and the highest one present is reported in `iir_byte[3:0]`. The ranking is: overrun with enable bit 2 (code 0x6); receive data present with enable bit 0 (code 0xC); transmitter-empty pending with enable bit 1 (code 0x2); modem delta with enable bit 3 (code 0x0).
- R2: When no enabled reason is active, `iir_byte[3:0]` reads 0x1.
- R3: A transmit-data write (`thr_wr`) sets the transmitter-empty pending flag from the next cycle on.
- R4: An enable write sets the pending flag when it changes enable bit 1 from 0 to 1. An enable write that finds bit 1 already set, or clears it, leaves the flag as it was.
- R5: An identifier read (`iir_rd`) clears the pending flag only when code 0x2 is the value that read returns. If a higher reason is being reported, the flag survives the read.
- R6: `iir_byte[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iir_byte[5:4]` always reads 0.
- R7: `irq` is registered. One cycle after any clock edge, it is high exactly when `iir_byte[3:0]` was not 0x1 before that edge. After reset it is low.
- R8: An enable write stores only bits 3:0 of `ier_wdata`, and `ier_val` returns them from the next cycle on. After reset `ier_val` is 0.
- R9: When a transmit-data write and a clearing identifier read fall in the same cycle, the pending flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| thr_wr | input | 1 | Transmit-data write strobe |
| iir_rd | input | 1 | Identifier read strobe |
| overrun | input | 1 | Receive overrun flag |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| modem_delta | input | 1 | Any modem status delta bit set |
| fifo_en | input | 1 | FIFO mode enabled |
| ier_val | output | 4 | Stored enable bits |
| iir_byte | output | 8 | Interrupt identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
The random stimulus holds several reasons active at once under random enable masks. This separates a correct ranking from one that lets a lower reason win. Frequent identifier reads, mixed with writes that set the flag, show whether the pending flag is cleared only when 0x2 is reported. Directed cases cover the rest. A repeated enable write with bit 1 already set shows that only the edge sets the flag. A read taken while receive data masks the pending flag shows that the flag survives. A write colliding with a clearing read fixes which of the two wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W  = 8;
  localparam int IER_W  = 4;
  localparam int CODE_W = 4;

  // enable bit positions, decoded by the register file's software view
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_MODEM = 4'h0,
    CODE_NONE  = 4'h1,
    CODE_THRE  = 4'h2,
    CODE_LINE  = 4'h6,
    CODE_RXDAT = 4'hC
  } irq_code_e;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int EW = IER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [EW-1:0] en_q,
  output logic          thre_en_rise
);
  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:EW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata[EW-1:0];
  end

  assign thre_en_rise = wr && !en_q[EN_THRE] && wdata[EN_THRE];
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_data,
  input  logic set_edge,
  input  logic rd_clear,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pending <= 1'b0;
    else if (set_data || set_edge) pending <= 1'b1;
    else if (rd_clear)             pending <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int EW = IER_W
) (
  input  logic [EW-1:0] en,
  input  logic          overrun,
  input  logic          rx_nonempty,
  input  logic          thre_pending,
  input  logic          modem_delta,
  input  logic          fifo_en,
  output irq_code_e     code,
  output logic [DW-1:0] id_byte
);
  localparam int FLAG_LO = DW - 2;

  always_comb begin
    if (overrun && en[EN_LINE])               code = CODE_LINE;
    else if (rx_nonempty && en[EN_RX])        code = CODE_RXDAT;
    else if (thre_pending && en[EN_THRE])     code = CODE_THRE;
    else if (modem_delta && en[EN_MODEM])     code = CODE_MODEM;
    else                                      code = CODE_NONE;
  end

  assign id_byte[CODE_W-1:0] = code;

  for (genvar i = CODE_W; i < DW; i++) begin : g_hi
    if (i >= FLAG_LO) begin : g_flag
      assign id_byte[i] = fifo_en;
    end else begin : g_zero
      assign id_byte[i] = 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [REG_W-1:0] ier_wdata,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             overrun,
  input  logic             rx_nonempty,
  input  logic             modem_delta,
  input  logic             fifo_en,
  output logic [IER_W-1:0] ier_val,
  output logic [REG_W-1:0] iir_byte,
  output logic             irq
);
  logic      edge_set;
  logic      thre_pend;
  irq_code_e code;

  uart_irq_enable #(.DW(REG_W), .EW(IER_W)) en_i (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .en_q(ier_val), .thre_en_rise(edge_set)
  );

  uart_irq_thre_track thre_i (
    .clk(clk), .rst_n(rst_n), .set_data(thr_wr), .set_edge(edge_set),
    .rd_clear(iir_rd && (code == CODE_THRE)), .pending(thre_pend)
  );

  uart_irq_prio #(.DW(REG_W), .EW(IER_W)) prio_i (
    .en(ier_val), .overrun(overrun), .rx_nonempty(rx_nonempty),
    .thre_pending(thre_pend), .modem_delta(modem_delta), .fifo_en(fifo_en),
    .code(code), .id_byte(iir_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (code != CODE_NONE);
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ier_wr,
  input logic [REG_W-1:0] ier_wdata,
  input logic             thr_wr,
  input logic             iir_rd,
  input logic             overrun,
  input logic             rx_nonempty,
  input logic             modem_delta,
  input logic             fifo_en,
  input logic [IER_W-1:0] ier_val,
  input logic [REG_W-1:0] iir_byte,
  input logic             irq
);
  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && ier_val[EN_LINE]) |-> iir_byte[3:0] == 4'h6);

  // R3
  data_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !ier_wr) |=> ((ier_val[EN_THRE] && !(overrun && ier_val[EN_LINE])
      && !(rx_nonempty && ier_val[EN_RX])) -> iir_byte[3:0] == 4'h2));

  // R6
  fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_byte[7:4] == (fifo_en ? 4'hC : 4'h0));

  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(iir_byte[3:0]) != 4'h1));

  // R8
  ier_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_val == $past(ier_wdata[IER_W-1:0]));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
  .thr_wr(thr_wr), .iir_rd(iir_rd), .overrun(overrun),
  .rx_nonempty(rx_nonempty), .modem_delta(modem_delta), .fifo_en(fifo_en),
  .ier_val(ier_val), .iir_byte(iir_byte), .irq(irq)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/100ps
module uart_irq_ident_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ier_wr = 0, thr_wr = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic       overrun = 0, rx_nonempty = 0, modem_delta = 0, fifo_en = 0;
  logic [3:0] ier_val;
  logic [7:0] iir_byte;
  logic       irq;

  int checks = 0, errors = 0;
  logic [3:0] m_ier;
  logic       m_pend, m_irq;

  always #2.5 clk = ~clk;

  uart_irq_ident dut_i (.*);

  function automatic logic [3:0] exp_code(logic [3:0] en, logic pend);
    if (overrun && en[2])          return 4'h6;
    else if (rx_nonempty && en[0]) return 4'hC;
    else if (pend && en[1])        return 4'h2;
    else if (modem_delta && en[3]) return 4'h0;
    else                           return 4'h1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs already driven; check, clock, update model
  task automatic step(string req);
    logic [3:0] c;
    #1;
    c = exp_code(m_ier, m_pend);
    chk(req, {24'd0, iir_byte}, {24'd0, fifo_en, fifo_en, 2'b00, c});
    chk("R7", {31'd0, irq}, {31'd0, m_irq});
    chk("R8", {28'd0, ier_val}, {28'd0, m_ier});
    @(posedge clk);
    m_irq = (c != 4'h1);
    if (thr_wr || (ier_wr && !m_ier[1] && ier_wdata[1])) m_pend = 1'b1;
    else if (iir_rd && c == 4'h2) m_pend = 1'b0;
    if (ier_wr) m_ier = ier_wdata[3:0];
    @(negedge clk);
    ier_wr = 0; thr_wr = 0; iir_rd = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    m_ier = 0; m_pend = 0; m_irq = 0;
    #12 rst_n = 1;
    @(negedge clk);
    // reset state: R2 code 0x1, irq low
    step("R2");
    // R8: upper bits dropped; R4 edge sets pending
    ier_wr = 1; ier_wdata = 8'hF2; step("R8");
    step("R4");
    chk("R4", {24'd0, iir_byte}, 32'h02);
    iir_rd = 1; step("R5");
    chk("R5", {24'd0, iir_byte}, 32'h01);
    // R4: rewrite with bit1 already set, no new pending
    ier_wr = 1; ier_wdata = 8'h02; step("R4");
    step("R4");
    chk("R4", {24'd0, iir_byte}, 32'h01);
    // R3: data write sets pending
    thr_wr = 1; step("R3");
    chk("R3", {24'd0, iir_byte}, 32'h02);
    // R5: higher reason reported, pending survives
    ier_wr = 1; ier_wdata = 8'h03; rx_nonempty = 1; step("R5");
    iir_rd = 1; step("R5");
    rx_nonempty = 0; step("R5");
    chk("R5", {24'd0, iir_byte}, 32'h02);
    // R9: write and clearing read together
    iir_rd = 1; thr_wr = 1; step("R9");
    chk("R9", {24'd0, iir_byte}, 32'h02);
    // R1 full stack, R6 fifo flags
    fifo_en = 1; ier_wr = 1; ier_wdata = 8'h0F;
    overrun = 1; rx_nonempty = 1; modem_delta = 1; step("R6");
    step("R1");
    overrun = 0; step("R1");
    rx_nonempty = 0; iir_rd = 1; step("R1");
    step("R1");
    modem_delta = 0; step("R2");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      overrun     = ($urandom % 6) == 0;
      rx_nonempty = ($urandom % 3) == 0;
      modem_delta = ($urandom % 4) == 0;
      fifo_en     = $urandom % 2;
      thr_wr      = ($urandom % 5) == 0;
      iir_rd      = ($urandom % 3) == 0;
      ier_wr      = ($urandom % 6) == 0;
      ier_wdata   = 8'($urandom);
      step("R1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule